// File: doc/BRIEF.md
# H-Bridge Drive Arbiter with Fault Latching

This block turns two direction commands into gate enables for the high-side and low-side switches of a two-leg H-bridge. When the bridge is armed, each leg follows its command bit. A high bit drives the leg to the supply and a low bit drives it to ground. The block also drives an active-low status flag and a status bit showing whether the enable/disable pin pair currently arms the bridge.

Two separate paths can force the bridge off. The first is the pin pair: an active-high disable and an active-high enable. Both pass through synchronisers before use. The second is the fault inputs. An overcurrent or overtemperature event is stored. It is released only by a falling disable or a rising enable. A hold-off window after the last fault also keeps the switches off. An undervoltage condition forces the bridge off only while it is present.

While the bridge is forced off, a leg may still turn on its low-side switch to carry free-wheeling current, but only while that leg is sensed below ground. Every leg inserts a dead gap between switching off one of its switches and switching on the other.

Top module: `hbridge_guard`

## Requirements
- R1: While armed and free of faults, leg i (bit i of each vector, leg 0 being the first output) drives its high-side enable when cmd bit i is 1 and its low-side enable when it is 0. Forward (cmd=01) gives hs=01, ls=10. Reverse gives hs=10, ls=01. cmd=00 gives ls=11. cmd=11 gives hs=11.
- R2: When the synchronised disable is high or the synchronised enable is low, no high-side enable is asserted, the low-side enables follow R7, and stat_n is 0.
- R3: An overcurrent or overtemperature input turns all drive off and sets stat_n to 0. The condition stays stored after the input returns low.
- R4: A stored fault clears only on a falling edge of the synchronised disable or a rising edge of the synchronised enable.
- R5: Undervoltage turns all drive off with stat_n at 0. Both drive and flag come back without any pin edge once the undervoltage input returns low.
- R6: After the last cycle an overcurrent or overtemperature input was high, drive stays off for at least HOLDOFF_CYC cycles, even if a clearing edge arrives within that window.
- R7: While the bridge is forced off, the low-side enable of leg i is asserted only if neg_sense[i] was high in the previous cycle. The high-side enable of that leg stays off.
- R8: The high-side and low-side enables of one leg are never high together. A switch turns on only after at least DEAD_CYC cycles with both switches of that leg off.
- R9: bridge_armed is 1 only when the synchronised enable is 1 and the synchronised disable is 0. It is 0 for the other three pin combinations.
- R10: During reset, all gate enables, stat_n and bridge_armed are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Direction command, one bit per leg |
| dis_in | input | 1 | Asynchronous active-high disable pin |
| ena_in | input | 1 | Asynchronous active-high enable pin |
| flt_ovc | input | 1 | Overcurrent or short-circuit detect |
| flt_ot | input | 1 | Overtemperature detect |
| flt_uv | input | 1 | Supply undervoltage detect |
| neg_sense | input | 2 | Leg i output sensed below ground |
| hs_en | output | 2 | High-side gate enable per leg |
| ls_en | output | 2 | Low-side gate enable per leg |
| stat_n | output | 1 | Active-low status flag, low while drive is forced off |
| bridge_armed | output | 1 | Enable high and disable low, after synchronisation |

## Verification
Some properties are checked on every cycle in all scenarios: the no-overlap rule of each leg, the one-cycle break before a switch turns on, the condition for free-wheeling low-side drive, the release of the fault latch only on a clearing edge, and the absence of high-side drive after the flag is low. Other behaviour shows only in the bench's sequences. These include the four command patterns, the difference between a stored fault and self-clearing undervoltage, and the hold-off window overriding an early clearing edge. They also include the full dead gap length and the decode of the pin pair into the armed bit.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_req_e;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    localparam int CW = STAGES + 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [CW-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CW-2:0], raw[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign lvl[b]  = chain_q[STAGES-1];
        assign rise[b] = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall[b] = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/hbg_fault.sv
module hbg_fault #(
    parameter int HOLD = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic clr,
    output logic latched,
    output logic busy
);
    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        logic          latched;
        logic [HW-1:0] hold;
    } fst_t;

    fst_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (trip)     s_d.latched = 1'b1;
        else if (clr) s_d.latched = 1'b0;
        if (trip)                 s_d.hold = HW'(HOLD);
        else if (s_q.hold != '0)  s_d.hold = s_q.hold - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign latched = s_q.latched;
    assign busy    = (s_q.hold != '0);

    AST_TRIP_STORES: assert property (@(posedge clk) disable iff (!rst_n) trip |=> latched); // R3
    AST_RELEASE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(latched) |-> $past(clr)); // R4
    AST_HOLD_AFTER_TRIP: assert property (@(posedge clk) disable iff (!rst_n) trip |=> busy); // R6
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int DEAD = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_e req,
    output logic     hs,
    output logic     ls
);
    localparam int GW = $clog2(DEAD + 1);

    typedef struct packed {
        logic          hs;
        logic          ls;
        logic [GW-1:0] gap;
    } lst_t;

    lst_t s_d, s_q;
    logic gap_ok;

    always_comb begin
        s_d    = s_q;
        gap_ok = (s_q.gap == GW'(DEAD));
        s_d.hs = (req == LEG_HI) && (s_q.hs || (!s_q.ls && gap_ok));
        s_d.ls = (req == LEG_LO) && (s_q.ls || (!s_q.hs && gap_ok));
        if (s_q.hs || s_q.ls) s_d.gap = '0;
        else if (!gap_ok)     s_d.gap = s_q.gap + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{hs: 1'b0, ls: 1'b0, gap: GW'(DEAD)};
        else        s_q <= s_d;
    end

    assign hs = s_q.hs;
    assign ls = s_q.ls;

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) !(hs && ls)); // R8
    AST_HS_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs) |-> $past(!ls)); // R8
    AST_LS_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls) |-> $past(!hs)); // R8
    AST_HS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n) hs |-> $past(req == LEG_HI)); // R1
endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard
    import hbg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEAD_CYC    = 4,
    parameter int HOLDOFF_CYC = 10000,
    parameter int LEGS        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LEGS-1:0] cmd,
    input  logic            dis_in,
    input  logic            ena_in,
    input  logic            flt_ovc,
    input  logic            flt_ot,
    input  logic            flt_uv,
    input  logic [LEGS-1:0] neg_sense,
    output logic [LEGS-1:0] hs_en,
    output logic [LEGS-1:0] ls_en,
    output logic            stat_n,
    output logic            bridge_armed
);
    localparam int PIN_DIS = 0;
    localparam int PIN_ENA = 1;

    logic [1:0] pin_lvl, pin_rise, pin_fall;
    logic       clr_edge, trip_now, latched, busy, run;

    hbg_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({ena_in, dis_in}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign clr_edge = pin_fall[PIN_DIS] | pin_rise[PIN_ENA];
    assign trip_now = flt_ovc | flt_ot;

    hbg_fault #(.HOLD(HOLDOFF_CYC)) u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip   (trip_now),
        .clr    (clr_edge),
        .latched(latched),
        .busy   (busy)
    );

    assign bridge_armed = pin_lvl[PIN_ENA] & ~pin_lvl[PIN_DIS];
    assign run = bridge_armed & ~latched & ~busy & ~trip_now & ~flt_uv;
    assign stat_n = run;

    for (genvar i = 0; i < LEGS; i++) begin : g_leg
        leg_req_e req;

        always_comb begin
            if (run)               req = cmd[i] ? LEG_HI : LEG_LO;
            else if (neg_sense[i]) req = LEG_LO;
            else                   req = LEG_OFF;
        end

        hbg_leg #(.DEAD(DEAD_CYC)) u_leg (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req),
            .hs   (hs_en[i]),
            .ls   (ls_en[i])
        );

        AST_FREEWHEEL_ONLY_NEG: assert property (@(posedge clk) disable iff (!rst_n)
            ls_en[i] |-> $past(run || neg_sense[i])); // R7
    end

    AST_OFF_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_n |=> (hs_en == '0)); // R2
    AST_UV_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        flt_uv |-> !stat_n); // R5
endmodule

// File: tb/test_hbridge_guard.sv
module test_hbridge_guard;
    localparam int TB_DEAD = 3;
    localparam int TB_HOLD = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic       dis_in = 1'b0, ena_in = 1'b0;
    logic       flt_ovc = 1'b0, flt_ot = 1'b0, flt_uv = 1'b0;
    logic [1:0] neg_sense = 2'b00;
    logic [1:0] hs_en, ls_en;
    logic       stat_n, bridge_armed;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hbridge_guard #(.SYNC_STAGES(2), .DEAD_CYC(TB_DEAD), .HOLDOFF_CYC(TB_HOLD), .LEGS(2)) i_hbridge_guard (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .dis_in(dis_in), .ena_in(ena_in),
        .flt_ovc(flt_ovc), .flt_ot(flt_ot), .flt_uv(flt_uv), .neg_sense(neg_sense),
        .hs_en(hs_en), .ls_en(ls_en), .stat_n(stat_n), .bridge_armed(bridge_armed)
    );

    typedef struct {
        string      tag;
        logic [1:0] hs;
        logic [1:0] ls;
        logic       st;
        logic       arm;
    } exp_t;

    exp_t sb_q[$];

    // Monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (hs_en !== e.hs || ls_en !== e.ls || stat_n !== e.st || bridge_armed !== e.arm) begin
                n_bad++;
                $display("FAIL %s: actual hs=%b ls=%b st=%b arm=%b expected hs=%b ls=%b st=%b arm=%b",
                         e.tag, hs_en, ls_en, stat_n, bridge_armed, e.hs, e.ls, e.st, e.arm);
            end
        end
    end

    // Dead-gap and overlap monitor (R8)
    int  off_run [2] = '{TB_DEAD, TB_DEAD};
    bit  overlap_seen = 1'b0;
    logic [1:0] hs_prev = 2'b00, ls_prev = 2'b00;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                if (hs_en[i] && ls_en[i]) overlap_seen = 1'b1;
                if ((hs_en[i] && !hs_prev[i]) || (ls_en[i] && !ls_prev[i])) begin
                    n_cmp++;
                    if (off_run[i] < TB_DEAD) begin
                        n_bad++;
                        $display("FAIL R8 dead gap leg %0d: actual %0d expected >= %0d", i, off_run[i], TB_DEAD);
                    end
                end
                if (!hs_en[i] && !ls_en[i]) off_run[i]++;
                else                        off_run[i] = 0;
            end
        end
        hs_prev = hs_en;
        ls_prev = ls_en;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_state(input string tag, input logic [1:0] hs, input logic [1:0] ls,
                                input logic st, input logic arm);
        exp_t e;
        e.tag = tag; e.hs = hs; e.ls = ls; e.st = st; e.arm = arm;
        sb_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        step(4);
        expect_state("R10 reset", 2'b00, 2'b00, 1'b0, 1'b0);
        rst_n = 1'b1;
        ena_in = 1'b1;
        step(12);
        expect_state("R1 both low", 2'b00, 2'b11, 1'b1, 1'b1);
        cmd = 2'b01; step(12);
        expect_state("R1 forward", 2'b01, 2'b10, 1'b1, 1'b1);
        cmd = 2'b10; step(12);
        expect_state("R1 reverse", 2'b10, 2'b01, 1'b1, 1'b1);
        cmd = 2'b11; step(12);
        expect_state("R1 both high", 2'b11, 2'b00, 1'b1, 1'b1);

        dis_in = 1'b1; step(12);
        expect_state("R2 disable high", 2'b00, 2'b00, 1'b0, 1'b0);
        ena_in = 1'b0; step(12);
        expect_state("R9 en0 di1", 2'b00, 2'b00, 1'b0, 1'b0);
        dis_in = 1'b0; step(12);
        expect_state("R2 enable low", 2'b00, 2'b00, 1'b0, 1'b0);
        ena_in = 1'b1; step(12);
        expect_state("R9 en1 di0", 2'b11, 2'b00, 1'b1, 1'b1);

        // Stored overcurrent, cleared by enable rise
        cmd = 2'b01; step(12);
        flt_ovc = 1'b1; step(3); flt_ovc = 1'b0;
        step(4);
        expect_state("R3 overcurrent off", 2'b00, 2'b00, 1'b0, 1'b1);
        step(TB_HOLD + 10);
        expect_state("R3 overcurrent stored", 2'b00, 2'b00, 1'b0, 1'b1);
        ena_in = 1'b0; step(6); ena_in = 1'b1; step(14);
        expect_state("R4 cleared by enable rise", 2'b01, 2'b10, 1'b1, 1'b1);

        // Stored overtemperature, cleared by disable fall
        flt_ot = 1'b1; step(2); flt_ot = 1'b0;
        step(TB_HOLD + 10);
        expect_state("R3 overtemp stored", 2'b00, 2'b00, 1'b0, 1'b1);
        dis_in = 1'b1; step(8);
        expect_state("R4 disable rise no clear", 2'b00, 2'b00, 1'b0, 1'b0);
        dis_in = 1'b0; step(14);
        expect_state("R4 cleared by disable fall", 2'b01, 2'b10, 1'b1, 1'b1);

        // Undervoltage self-recovers
        flt_uv = 1'b1; step(4);
        expect_state("R5 undervoltage off", 2'b00, 2'b00, 1'b0, 1'b1);
        flt_uv = 1'b0; step(12);
        expect_state("R5 undervoltage recovered", 2'b01, 2'b10, 1'b1, 1'b1);

        // Hold-off overrides an early clearing edge
        flt_ovc = 1'b1; step(1); flt_ovc = 1'b0;
        ena_in = 1'b0; step(4); ena_in = 1'b1;
        step(14);
        expect_state("R6 hold-off still off", 2'b00, 2'b00, 1'b0, 1'b1);
        step(TB_HOLD + 5);
        expect_state("R6 after hold-off", 2'b01, 2'b10, 1'b1, 1'b1);

        // Free-wheeling while forced off
        ena_in = 1'b0; step(12);
        expect_state("R7 off no sense", 2'b00, 2'b00, 1'b0, 1'b0);
        neg_sense = 2'b01; step(10);
        expect_state("R7 leg0 below ground", 2'b00, 2'b01, 1'b0, 1'b0);
        neg_sense = 2'b10; step(10);
        expect_state("R7 leg1 below ground", 2'b00, 2'b10, 1'b0, 1'b0);
        neg_sense = 2'b00; step(3);
        expect_state("R7 sense gone", 2'b00, 2'b00, 1'b0, 1'b0);

        // Fast reversals to stress the dead gap
        ena_in = 1'b1; cmd = 2'b01; step(12);
        cmd = 2'b10; step(2); cmd = 2'b01; step(12);
        expect_state("R8 after quick reversal", 2'b01, 2'b10, 1'b1, 1'b1);

        n_cmp++;
        if (overlap_seen) begin
            n_bad++;
            $display("FAIL R8 overlap: actual=seen expected=none");
        end
        done = 1'b1;
        summary();
    end
endmodule